// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It looks up a two-level page table that lives in ordinary memory, and it handles one request at a time. A request carries a virtual address and an access type, read or write. The walker then issues word reads on a memory request/response port. The first read fetches a first-level entry. That entry points to a second-level table, and a second read fetches the leaf entry. The leaf holds the frame number, the flag bits and the write permission.

When a translation succeeds, the walker marks the leaf as referenced, and also as dirty for a write access. It does this with a single write-back, issued only when the word would change. The result is a physical address or a fault code, and a one-cycle done pulse accompanies it. A table base register locates the first-level table. Software can load this register only while the privileged-mode input is high.

Pages are 8 KB. Virtual bits [31:22] index the first level, bits [21:13] index the second level, and bits [12:0] pass through as the page offset.

Two handshakes govern the ports:
- The request port is valid/ready. A request is taken in a cycle where both are high, and ready is high only while the walker is idle.
- The memory request port is valid/ready. Once the walker raises valid, it holds address, write flag and write data unchanged until the memory raises ready.
- A write completes on its handshake.
- Each read completes when the memory raises its response-valid strobe for one cycle. The strobe may arrive any number of cycles after the handshake.

Top module: `ptw_top`

## Requirements
- R1: After reset, req_ready_o is 1, and done_o and mem_req_valid_o are 0.
- R2: A request is accepted only in a cycle with req_valid_i and req_ready_o both high. req_ready_o stays low from acceptance until one cycle after done_o.
- R3: The first memory access of a walk is a read of address base + 4 × vaddr[31:22], using the base value held in the acceptance cycle.
- R4: A first-level entry with bit 0 clear ends the walk with fault 01. The walk makes exactly one read and no write. Otherwise, bits [31:13] of that entry are the pointer to the second-level table.
- R5: The second read is at address {pointer, 13'b0} + 4 × vaddr[21:13].
- R6: The leaf entry uses bit 0 for valid, bit 1 for referenced, bit 2 for dirty, bit 3 for write permission, and bits [31:13] for the frame. A leaf with bit 0 clear gives fault 10 and no write.
- R7: A successful walk gives fault 00 and physical address {frame, vaddr[12:0]}. It writes the leaf back to the same address with bit 1 set. The write is issued only if the word changes.
- R8: On a successful write access, the write-back also sets bit 2.
- R9: A write access to a valid leaf with bit 3 clear gives fault 11 and no write. A read access to a valid leaf never gives a protection fault.
- R10: The base register takes base_wdata_i when base_we_i and priv_i are both high, and ignores the write when priv_i is low.
- R11: A base write in the same cycle as request acceptance does not affect that walk; the walk after it uses the new value.
- R12: The memory request stays stable while it is not accepted. The walker waits any number of cycles for each read response.
- R13: done_o is high for exactly one cycle per walk. On any fault, resp_paddr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 1 | Privileged mode; enables base register writes |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 32 | New base register value |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| done_o | output | 1 | One-cycle result strobe |
| resp_paddr_o | output | 32 | Physical address (0 on fault) |
| resp_fault_o | output | 2 | 00 none, 01 first-level invalid, 10 leaf invalid, 11 protection |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Memory request is a write |
| mem_req_addr_o | output | 32 | Memory byte address |
| mem_req_wdata_o | output | 32 | Write data (leaf write-back) |
| mem_rsp_valid_i | input | 1 | Read data valid strobe |
| mem_rsp_rdata_i | input | 32 | Read data |

## Verification
A base register write and the acceptance of a translation request can happen in the same clock cycle. The bench provokes this by raising req_valid_i together with a privileged base write in a single cycle. It judges the outcome by the address of the walk's first-level read, which must come from the old base. The next walk's first-level read must come from the new base. Around this, a sweep covers every combination of first-level valid, leaf valid, referenced, dirty, write permission and access type. Each case runs under varying read latency and request back-pressure.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PTW_OFF_W = 13;
  localparam int unsigned PTW_L1_W  = 10;
  localparam int unsigned PTW_L2_W  = 9;

  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_R = 1;
  localparam int unsigned PTE_D = 2;
  localparam int unsigned PTE_W = 3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_L1   = 2'b01,
    FLT_L2   = 2'b10,
    FLT_PROT = 2'b11
  } ptw_fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_UPD_REQ, S_DONE
  } ptw_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned OFF_W = ptw_pkg::PTW_OFF_W,
  parameter int unsigned L1_W  = ptw_pkg::PTW_L1_W,
  parameter int unsigned L2_W  = ptw_pkg::PTW_L2_W,
  parameter int unsigned VA_W  = OFF_W + L1_W + L2_W
) (
  input  logic [VA_W-1:0]       base_i,
  input  logic [L1_W-1:0]       idx1_i,
  input  logic [L2_W-1:0]       idx2_i,
  input  logic [VA_W-OFF_W-1:0] ptr_i,
  output logic [VA_W-1:0]       l1_addr_o,
  output logic [VA_W-1:0]       l2_addr_o
);
  localparam int unsigned PAD1 = VA_W - L1_W - 2;
  localparam int unsigned PAD2 = VA_W - L2_W - 2;

  assign l1_addr_o = base_i + {{PAD1{1'b0}}, idx1_i, 2'b00};
  assign l2_addr_o = {ptr_i, {OFF_W{1'b0}}} + {{PAD2{1'b0}}, idx2_i, 2'b00};
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int unsigned OFF_W = ptw_pkg::PTW_OFF_W,
  parameter int unsigned VA_W  = 32
) (
  input  logic [VA_W-1:0]  entry_i,
  input  logic             is_write_i,
  input  logic [OFF_W-1:0] offset_i,
  output ptw_fault_e       fault_o,
  output logic             need_wb_o,
  output logic [VA_W-1:0]  new_entry_o,
  output logic [VA_W-1:0]  paddr_o
);
  logic [VA_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[PTE_R] = 1'b1;
    set_mask[PTE_D] = is_write_i;
  end

  always_comb begin
    if (!entry_i[PTE_V])                      fault_o = FLT_L2;
    else if (is_write_i && !entry_i[PTE_W])   fault_o = FLT_PROT;
    else                                      fault_o = FLT_NONE;
  end

  assign new_entry_o = entry_i | set_mask;
  assign need_wb_o   = (new_entry_o != entry_i);
  assign paddr_o     = {entry_i[VA_W-1:OFF_W], offset_i};
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned OFF_W = ptw_pkg::PTW_OFF_W,
  parameter int unsigned L1_W  = ptw_pkg::PTW_L1_W,
  parameter int unsigned L2_W  = ptw_pkg::PTW_L2_W,
  parameter int unsigned VA_W  = OFF_W + L1_W + L2_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_i,
  input  logic            base_we_i,
  input  logic [VA_W-1:0] base_wdata_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  output logic            done_o,
  output logic [VA_W-1:0] resp_paddr_o,
  output logic [1:0]      resp_fault_o,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic            mem_req_we_o,
  output logic [VA_W-1:0] mem_req_addr_o,
  output logic [VA_W-1:0] mem_req_wdata_o,
  input  logic            mem_rsp_valid_i,
  input  logic [VA_W-1:0] mem_rsp_rdata_i
);
  localparam int unsigned LOW_W = L2_W + OFF_W;

  ptw_state_e      state_q;
  logic [VA_W-1:0] base_q;
  logic [LOW_W-1:0] vlow_q;
  logic            write_q;
  logic [VA_W-1:0] l1_addr_q, l2_addr_q, wb_q;
  logic [VA_W-1:0] paddr_q;
  ptw_fault_e      fault_q;

  logic [VA_W-1:0] l1_addr, l2_addr;
  ptw_fault_e      leaf_fault;
  logic            leaf_need_wb;
  logic [VA_W-1:0] leaf_new, leaf_paddr;

  ptw_addr_gen #(.OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W), .VA_W(VA_W)) u_addr (
    .base_i   (base_q),
    .idx1_i   (req_vaddr_i[VA_W-1:LOW_W]),
    .idx2_i   (vlow_q[LOW_W-1:OFF_W]),
    .ptr_i    (mem_rsp_rdata_i[VA_W-1:OFF_W]),
    .l1_addr_o(l1_addr),
    .l2_addr_o(l2_addr)
  );

  ptw_leaf_eval #(.OFF_W(OFF_W), .VA_W(VA_W)) u_leaf (
    .entry_i    (mem_rsp_rdata_i),
    .is_write_i (write_q),
    .offset_i   (vlow_q[OFF_W-1:0]),
    .fault_o    (leaf_fault),
    .need_wb_o  (leaf_need_wb),
    .new_entry_o(leaf_new),
    .paddr_o    (leaf_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we_i && priv_i) begin
      base_q <= base_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      vlow_q    <= '0;
      write_q   <= 1'b0;
      l1_addr_q <= '0;
      l2_addr_q <= '0;
      wb_q      <= '0;
      paddr_q   <= '0;
      fault_q   <= FLT_NONE;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          vlow_q    <= req_vaddr_i[LOW_W-1:0];
          write_q   <= req_write_i;
          l1_addr_q <= l1_addr;
          state_q   <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready_i) state_q <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid_i) begin
          if (!mem_rsp_rdata_i[PTE_V]) begin
            fault_q <= FLT_L1;
            paddr_q <= '0;
            state_q <= S_DONE;
          end else begin
            l2_addr_q <= l2_addr;
            state_q   <= S_L2_REQ;
          end
        end
        S_L2_REQ: if (mem_req_ready_i) state_q <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid_i) begin
          fault_q <= leaf_fault;
          paddr_q <= (leaf_fault == FLT_NONE) ? leaf_paddr : '0;
          wb_q    <= leaf_new;
          state_q <= (leaf_fault == FLT_NONE && leaf_need_wb) ? S_UPD_REQ : S_DONE;
        end
        S_UPD_REQ: if (mem_req_ready_i) state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = l2_addr_q;
    case (state_q)
      S_L1_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = l1_addr_q;
      end
      S_L2_REQ:  mem_req_valid_o = 1'b1;
      S_UPD_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_req_wdata_o = wb_q;
  assign req_ready_o     = (state_q == S_IDLE);
  assign done_o          = (state_q == S_DONE);
  assign resp_paddr_o    = paddr_q;
  assign resp_fault_o    = fault_q;
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk #(
  parameter int unsigned VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            priv_i,
  input logic            base_we_i,
  input logic [VA_W-1:0] base_q,
  input logic            req_ready_o,
  input logic            done_o,
  input logic [VA_W-1:0] resp_paddr_o,
  input logic [1:0]      resp_fault_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic            mem_req_we_o,
  input logic [VA_W-1:0] mem_req_addr_o,
  input logic [VA_W-1:0] mem_req_wdata_o
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_we_o) && $stable(mem_req_wdata_o));

  a_r2_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> !req_ready_o);

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r13_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && resp_fault_o != 2'b00 |-> resp_paddr_o == '0);

  a_r7_wb_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[1] && mem_req_wdata_o[0]);

  a_r10_base_guard: assert property (@(posedge clk) disable iff (!rst_n)
    base_we_i && !priv_i |=> $stable(base_q));
endmodule

bind ptw_top ptw_top_chk #(.VA_W(VA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .priv_i         (priv_i),
  .base_we_i      (base_we_i),
  .base_q         (base_q),
  .req_ready_o    (req_ready_o),
  .done_o         (done_o),
  .resp_paddr_o   (resp_paddr_o),
  .resp_fault_o   (resp_fault_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_we_o   (mem_req_we_o),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o)
);

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_i = 1'b0, base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_ready_o, done_o;
  logic [31:0] resp_paddr_o;
  logic [1:0]  resp_fault_o;
  logic        mem_req_valid_o, mem_req_we_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o, mem_req_wdata_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_rdata_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top u_dut (.*);

  logic [31:0] mem [0:4095];
  int          n_cmp = 0, n_err = 0;
  int          cfg_delay = 0;
  bit          cfg_stall = 1'b0;
  int          cyc = 0, rd_cnt = 0, wr_cnt = 0, dly = 0;
  bit          pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [31:0] rd_log [0:3];
  logic [31:0] wr_addr_last = '0, wr_data_last = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid_i <= 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_rdata_i <= mem[pend_addr[13:2]];
        pend <= 1'b0;
      end else dly <= dly - 1;
    end
    if (mem_req_valid_o && mem_req_ready_i) begin
      if (mem_req_we_o) begin
        wr_cnt       <= wr_cnt + 1;
        wr_addr_last <= mem_req_addr_o;
        wr_data_last <= mem_req_wdata_o;
      end else begin
        rd_log[rd_cnt % 4] <= mem_req_addr_o;
        rd_cnt    <= rd_cnt + 1;
        pend      <= 1'b1;
        pend_addr <= mem_req_addr_o;
        dly       <= cfg_delay;
      end
    end
    mem_req_ready_i <= cfg_stall ? (cyc % 3 == 2) : 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic base_write(input bit p, input logic [31:0] v);
    @(negedge clk);
    priv_i = p; base_we_i = 1'b1; base_wdata_i = v;
    @(negedge clk);
    priv_i = 1'b0; base_we_i = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input bit with_base,
                      input logic [31:0] nb, output logic [1:0] flt, output logic [31:0] pa);
    @(negedge clk);
    req_vaddr_i = va; req_write_i = wr; req_valid_i = 1'b1;
    if (with_base) begin priv_i = 1'b1; base_we_i = 1'b1; base_wdata_i = nb; end
    do @(posedge clk); while (!req_ready_o);
    @(negedge clk);
    req_valid_i = 1'b0; priv_i = 1'b0; base_we_i = 1'b0;
    while (!done_o) @(negedge clk);
    flt = resp_fault_o; pa = resp_paddr_o;
    @(negedge clk);
    chk("R13 done pulse", {31'd0, done_o}, 32'd0);
    chk("R2 ready after done", {31'd0, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [1:0]  flt;
    logic [31:0] pa;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 memvalid", {31'd0, mem_req_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 64; c++) begin
      bit l1v, v, r, d, w, wr, ok;
      logic [9:0]  i1;
      logic [8:0]  i2;
      logic [12:0] off;
      logic [18:0] frame;
      logic [31:0] leaf, l2a, l1a, exp_new;
      int r0, w0, exp_rd, exp_wr;
      logic [1:0] exp_f;
      string ptag;
      l1v = c[0]; v = c[1]; r = c[2]; d = c[3]; w = c[4]; wr = c[5];
      i1 = 10'((c * 37 + 5) % 1024);
      i2 = 9'((c * 53 + 3) % 512);
      off = 13'((c * 611 + 7) % 8192);
      frame = 19'((c * 9973 + 1) % 524288);
      cfg_delay = c % 4;
      cfg_stall = c[3] ^ c[0];
      l1a = {20'd0, i1, 2'b00};
      l2a = 32'h2000 + {21'd0, i2, 2'b00};
      leaf = {frame, 9'd0, w, d, r, v};
      mem[l1a[13:2]] = 32'h0000_2000 | {31'd0, l1v};
      mem[l2a[13:2]] = leaf;
      exp_new = leaf | 32'h2 | (wr ? 32'h4 : 32'h0);
      ok = 1'b0;
      if (!l1v)          begin exp_f = 2'b01; exp_rd = 1; exp_wr = 0; end
      else if (!v)       begin exp_f = 2'b10; exp_rd = 2; exp_wr = 0; end
      else if (wr && !w) begin exp_f = 2'b11; exp_rd = 2; exp_wr = 0; end
      else begin exp_f = 2'b00; exp_rd = 2; exp_wr = (exp_new != leaf) ? 1 : 0; ok = 1'b1; end
      r0 = rd_cnt; w0 = wr_cnt;
      walk({i1, i2, off}, wr, 1'b0, '0, flt, pa);
      ptag = cfg_stall ? "R12 paddr under stall" : "R7 paddr";
      chk(!l1v ? "R4 fault" : !v ? "R6 fault" : (wr && !w) ? "R9 fault" : "R7 fault",
          {30'd0, flt}, {30'd0, exp_f});
      chk(ptag, pa, ok ? {frame, off} : 32'd0);
      chk("R4 read count", rd_cnt - r0, exp_rd);
      chk("R9 write count", wr_cnt - w0, exp_wr);
      chk("R3 l1 addr", rd_log[r0 % 4], l1a);
      if (l1v) chk("R5 l2 addr", rd_log[(r0 + 1) % 4], l2a);
      if (exp_wr == 1) begin
        chk("R7 wb addr", wr_addr_last, l2a);
        chk(wr ? "R8 wb data" : "R7 wb data", wr_data_last, exp_new);
      end
    end

    cfg_stall = 1'b0; cfg_delay = 1;
    base_write(1'b0, 32'h1000);
    mem[5] = 32'h2001;
    mem[2048 + 7] = {19'h1234, 9'd0, 4'b1011};
    begin
      int r0;
      r0 = rd_cnt;
      walk({10'd5, 9'd7, 13'h0abc}, 1'b0, 1'b0, '0, flt, pa);
      chk("R10 base ignored", rd_log[r0 % 4], 32'h14);
      chk("R10 paddr", pa, {19'h1234, 13'h0abc});
      r0 = rd_cnt;
      walk({10'd5, 9'd7, 13'h0001}, 1'b1, 1'b1, 32'h1000, flt, pa);
      chk("R11 same-cycle old base", rd_log[r0 % 4], 32'h14);
      mem[1024 + 6] = 32'h2001;
      r0 = rd_cnt;
      walk({10'd6, 9'd7, 13'h0002}, 1'b0, 1'b0, '0, flt, pa);
      chk("R11 next walk new base", rd_log[r0 % 4], 32'h1018);
      chk("R11 fault", {30'd0, flt}, 32'd0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule